// File: doc/BRIEF.md
# Dual Framebuffer Read Address Sequencer

This block produces burst read requests for a display pixel fetch engine. Two framebuffer regions can be programmed. Each region is described by a start address and an inclusive ceiling, which is the address of its last byte. The sequencer walks a region in word steps and asks for bursts of a programmable length. It shortens the final burst so that the burst ends exactly on the ceiling word. When a region is finished, it raises that region's own end-of-frame pulse.

A mode input selects between two schemes. In the first, the sequencer fetches from region 0 on every pass. In the second, it alternates between region 0 and region 1 (ping-pong). At the start of each pass, the sequencer copies the region's start, ceiling and burst length into working registers. Software can therefore rewrite a region's pair in response to its end-of-frame pulse, and the new values apply only to that region's next pass.

The memory bus is represented by a simple request/grant pair, and the downstream pixel FIFO by a "wants data" level. The control state machine has four states:

- **IDLE**: nothing is fetched.
- **LOAD**: the working copies are latched.
- **WAIT**: the sequencer waits for the FIFO to want data.
- **REQ**: a burst request is held until it is granted.

Its transitions are:

- IDLE→LOAD when `run` is high.
- LOAD→WAIT always.
- WAIT→IDLE when `run` is low.
- WAIT→REQ when `run` and `fifo_want` are high.
- REQ→WAIT on a grant that is not the last burst of the pass.
- REQ→LOAD on a grant of the last burst. This transition also selects the next region.

Top module: `fb_dual_dma_seq`

## Requirements
- R1: After reset, `rd_req`, `eof0` and `eof1` are low. While `run` stays low, no request is made.
- R2: A new request is raised only one cycle after a clock edge at which both `run` and `fifo_want` were high. While `fifo_want` is low after a grant, `rd_req` stays low.
- R3: The first burst of a pass reads from the region's start address, with its two low bits forced to zero.
- R4: Each later burst of a pass starts 4 × (beats of the previous burst) bytes above the previous start.
- R5: `burst_code` values 0 to 4 select 1, 2, 4, 8 or 16 beats (2 to the power of the code). Values 5, 6 and 7 select 16 beats. The code is sampled when a pass starts.
- R6: When fewer words than the burst length remain up to the ceiling word, the burst is shortened so that its last beat reads the word that holds the ceiling byte.
- R7: On the clock edge that grants the last burst of a region-0 pass, `eof0` rises for exactly one cycle. On the corresponding grant for a region-1 pass, `eof1` does the same. The two pulses never occur together.
- R8: When `pingpong` is 0 at the end of a pass, the next pass uses region 0. When `pingpong` is 1, the next pass uses the other region.
- R9: The configuration write port uses select 0 for region-0 start, 1 for region-0 ceiling, 2 for region-1 start and 3 for region-1 ceiling. A write made during a pass does not change that pass. It takes effect at the next pass that uses the written region.
- R10: While `rd_req` is high and `rd_gnt` is low, `rd_req`, `rd_addr` and `rd_beats` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 start0, 1 ceil0, 2 start1, 3 ceil1 |
| cfg_wdata | input | AW | Configuration write data (byte address) |
| pingpong | input | 1 | 0: region 0 only, 1: alternate regions |
| burst_code | input | 3 | Burst length exponent |
| run | input | 1 | Fetch enable |
| fifo_want | input | 1 | Downstream FIFO wants more data |
| rd_req | output | 1 | Burst read request |
| rd_addr | output | AW | Burst start byte address |
| rd_beats | output | MAXLOG+1 | Burst length in words |
| rd_gnt | input | 1 | Grant; completes the pending request at this edge |
| eof0 | output | 1 | One-cycle end-of-frame pulse, region 0 |
| eof1 | output | 1 | One-cycle end-of-frame pulse, region 1 |

## Verification
The first request appears two cycles after `run` is first seen high. After a non-final grant, the next request appears one cycle after the first edge at which `fifo_want` is high. An end-of-frame pulse is visible in the cycle right after the granting edge. The bench therefore acts as a transaction-level bus. It waits on the falling edge for `rd_req` and compares address and beat count against a model that tracks working copies, pointer and region. It grants, and samples both end-of-frame outputs on the very next falling edge. While the grant is held back, and during stretches with `fifo_want` low, it checks on each falling edge that the request holds or stays absent.

// File: rtl/fb_dual_dma_seq_pkg.sv
package fb_dual_dma_seq_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LOAD = 2'd1,
        S_WAIT = 2'd2,
        S_REQ  = 2'd3
    } seq_state_e;

    localparam logic [1:0] SEL_START0 = 2'd0;
    localparam logic [1:0] SEL_CEIL0  = 2'd1;
    localparam logic [1:0] SEL_START1 = 2'd2;
    localparam logic [1:0] SEL_CEIL1  = 2'd3;

endpackage

// File: rtl/fb_dual_dma_seq_regs.sv
module fb_dual_dma_seq_regs #(
    parameter int AW   = 32,
    parameter int NBUF = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [1:0]               cfg_sel,
    input  logic [AW-1:0]            cfg_wdata,
    output logic [NBUF-1:0][AW-1:0]  start_q,
    output logic [NBUF-1:0][AW-1:0]  ceil_q
);

    for (genvar g = 0; g < NBUF; g++) begin : g_region
        localparam logic [1:0] START_SEL = 2'(2 * g);
        localparam logic [1:0] CEIL_SEL  = 2'(2 * g + 1);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                start_q[g] <= '0;
                ceil_q[g]  <= '0;
            end else if (cfg_we) begin
                if (cfg_sel == START_SEL) start_q[g] <= cfg_wdata;
                if (cfg_sel == CEIL_SEL)  ceil_q[g]  <= cfg_wdata;
            end
        end
    end

endmodule

// File: rtl/fb_dual_dma_seq_bdec.sv
module fb_dual_dma_seq_bdec #(
    parameter int MAXLOG = 4,
    parameter int BW     = MAXLOG + 1
) (
    input  logic [2:0]    code,
    output logic [BW-1:0] words
);

    localparam logic [BW-1:0] ONE = BW'(1);

    always_comb begin
        if (int'(code) <= MAXLOG) words = ONE << code;
        else                      words = ONE << MAXLOG;
    end

endmodule

// File: rtl/fb_dual_dma_seq_span.sv
module fb_dual_dma_seq_span #(
    parameter int AW = 32,
    parameter int BW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_start,
    input  logic [AW-1:0] load_ceil,
    input  logic [BW-1:0] load_burst,
    input  logic          advance,
    output logic [AW-1:0] ptr,
    output logic [AW-1:0] work_ceil,
    output logic [BW-1:0] beats,
    output logic          last
);

    localparam int WW = AW - 2;

    logic [AW-1:0] ptr_q, ceil_q;
    logic [BW-1:0] burst_q;
    logic [WW-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            ceil_q  <= '0;
            burst_q <= BW'(1);
        end else if (load) begin
            ptr_q   <= {load_start[AW-1:2], 2'b00};
            ceil_q  <= load_ceil;
            burst_q <= load_burst;
        end else if (advance) begin
            ptr_q <= ptr_q + {{(AW-BW-2){1'b0}}, beats, 2'b00};
        end
    end

    always_comb begin
        remain = ceil_q[AW-1:2] - ptr_q[AW-1:2] + WW'(1);
        last   = (remain <= WW'(burst_q));
        beats  = last ? remain[BW-1:0] : burst_q;
    end

    assign ptr       = ptr_q;
    assign work_ceil = ceil_q;

    // R5
    beats_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> (beats != '0) && (beats <= burst_q));

endmodule

// File: rtl/fb_dual_dma_seq.sv
module fb_dual_dma_seq
    import fb_dual_dma_seq_pkg::*;
#(
    parameter int AW     = 32,
    parameter int MAXLOG = 4,
    parameter int BW     = MAXLOG + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          pingpong,
    input  logic [2:0]    burst_code,
    input  logic          run,
    input  logic          fifo_want,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    output logic [BW-1:0] rd_beats,
    input  logic          rd_gnt,
    output logic          eof0,
    output logic          eof1
);

    localparam int NBUF = 2;
    localparam int WW   = AW - 2;

    seq_state_e state_q, state_d;
    logic       buf_q, buf_d;
    logic       load, advance, last;
    logic       eof0_q, eof1_q;

    logic [NBUF-1:0][AW-1:0] start_q, ceil_q;
    logic [BW-1:0]           burst_words;
    logic [AW-1:0]           ptr, work_ceil;
    logic [BW-1:0]           beats;

    fb_dual_dma_seq_regs #(.AW(AW), .NBUF(NBUF)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .start_q(start_q), .ceil_q(ceil_q)
    );

    fb_dual_dma_seq_bdec #(.MAXLOG(MAXLOG), .BW(BW)) u_bdec (
        .code(burst_code), .words(burst_words)
    );

    fb_dual_dma_seq_span #(.AW(AW), .BW(BW)) u_span (
        .clk(clk), .rst_n(rst_n), .load(load),
        .load_start(start_q[buf_q]), .load_ceil(ceil_q[buf_q]),
        .load_burst(burst_words), .advance(advance),
        .ptr(ptr), .work_ceil(work_ceil), .beats(beats), .last(last)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            buf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            buf_q   <= buf_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        buf_d   = buf_q;
        unique case (state_q)
            S_IDLE: if (run) state_d = S_LOAD;
            S_LOAD: state_d = S_WAIT;
            S_WAIT: begin
                if (!run)           state_d = S_IDLE;
                else if (fifo_want) state_d = S_REQ;
            end
            S_REQ: begin
                if (rd_gnt) begin
                    if (last) begin
                        state_d = S_LOAD;
                        buf_d   = pingpong ? ~buf_q : 1'b0;
                    end else begin
                        state_d = S_WAIT;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rd_req   = (state_q == S_REQ);
        rd_addr  = ptr;
        rd_beats = beats;
        load     = (state_q == S_LOAD);
        advance  = rd_req && rd_gnt;
        eof0     = eof0_q;
        eof1     = eof1_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eof0_q <= 1'b0;
            eof1_q <= 1'b0;
        end else begin
            eof0_q <= advance && last && !buf_q;
            eof1_q <= advance && last &&  buf_q;
        end
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_gnt) |=> (rd_req && $stable(rd_addr) && $stable(rd_beats)));

    // R2
    req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_req) |-> $past(run && fifo_want));

    // R6
    ceil_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> ((rd_addr[AW-1:2] + WW'(rd_beats) - WW'(1)) <= work_ceil[AW-1:2]));

    // R7
    eof_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(eof0 && eof1));

    // R7
    eof_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eof0 || eof1) |=> !(eof0 || eof1));

endmodule

// File: tb/fb_dual_dma_seq_tb.sv
module fb_dual_dma_seq_tb;

    localparam int AW = 32;
    localparam int MAXLOG = 4;
    localparam int BW = MAXLOG + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          pingpong = 1'b0;
    logic [2:0]    burst_code = 3'd2;
    logic          run = 1'b0;
    logic          fifo_want = 1'b1;
    logic          rd_gnt = 1'b0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic [BW-1:0] rd_beats;
    logic          eof0, eof1;

    always #10 clk = ~clk;

    fb_dual_dma_seq #(.AW(AW), .MAXLOG(MAXLOG)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .pingpong(pingpong), .burst_code(burst_code),
        .run(run), .fifo_want(fifo_want), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_beats(rd_beats), .rd_gnt(rd_gnt), .eof0(eof0), .eof1(eof1)
    );

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  hung     = 0;

    // model
    logic [AW-1:0] m_start [2];
    logic [AW-1:0] m_ceil  [2];
    logic [AW-1:0] w_ptr, w_ceil;
    int            w_burst;
    int            m_buf;
    bit            first_of_pass;
    bit            wrote_mid;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int dec_burst(input int code);
        return (code <= MAXLOG) ? (1 << code) : (1 << MAXLOG);
    endfunction

    task automatic load_pass();
        w_ptr   = {m_start[m_buf][AW-1:2], 2'b00};
        w_ceil  = m_ceil[m_buf];
        w_burst = dec_burst(int'(burst_code));
        first_of_pass = 1;
        wrote_mid = 0;
    endtask

    // Called at a falling edge; the write lands at the next rising edge.
    task automatic write_reg(input int sel, input logic [AW-1:0] v);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 0) m_start[0] = v;
        if (sel == 1) m_ceil[0]  = v;
        if (sel == 2) m_start[1] = v;
        if (sel == 3) m_ceil[1]  = v;
    endtask

    task automatic write_region(input int b, input int words);
        logic [AW-1:0] s, c;
        s = 32'h1000_0000 + 32'(($urandom % 4096) * 4);
        c = s + 32'((words - 1) * 4) + 32'($urandom % 4);
        write_reg(2 * b, s);
        write_reg(2 * b + 1, c);
    endtask

    // action: 0 none, 1 random, 2 directed mode change plus mid-pass rewrite
    task automatic do_burst(input int action, input int hold, input int gap);
        int waitc = 0;
        int rem, eb;
        bit lst;
        logic [AW-1:0] a0;
        logic [BW-1:0] b0;
        while (!rd_req && waitc < 2000) begin
            @(negedge clk);
            waitc++;
        end
        if (!rd_req) begin
            hung = 1;
            check(0, "R2", "request never raised", 0, 1);
            return;
        end
        rem = int'(w_ceil >> 2) - int'(w_ptr >> 2) + 1;
        eb  = (rem < w_burst) ? rem : w_burst;
        if (first_of_pass)
            check(rd_addr == w_ptr, "R3 R8", "pass start address", rd_addr, w_ptr);
        else if (wrote_mid)
            check(rd_addr == w_ptr, "R9", "address after mid-pass write", rd_addr, w_ptr);
        else
            check(rd_addr == w_ptr, "R4", "burst address", rd_addr, w_ptr);
        if (eb < w_burst)
            check(int'(rd_beats) == eb, "R6", "shortened beats", rd_beats, eb);
        else
            check(int'(rd_beats) == eb, "R5", "burst beats", rd_beats, eb);
        // R10: hold the grant back
        a0 = rd_addr; b0 = rd_beats;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            check(rd_req && rd_addr == a0 && rd_beats == b0, "R10",
                  "request held stable", rd_addr, a0);
        end
        if (action == 1) begin
            if ($urandom % 4 == 0) begin
                write_region(int'($urandom % 2), 1 + int'($urandom % 40));
                wrote_mid = 1;    // R9
            end
            if ($urandom % 4 == 0) pingpong = 1'($urandom);
            if ($urandom % 4 == 0) burst_code = 3'($urandom);
        end else if (action == 2) begin
            pingpong = 1'b1;
            burst_code = 3'd7;    // R5 fallback
            write_reg(0, 32'h0000_4000);   // R9 rewrite of region 0 mid-pass
            write_reg(1, 32'h0000_4000 + 32'd79);
            wrote_mid = 1;
        end
        rd_gnt = 1'b1;
        fifo_want = (gap == 0);
        @(negedge clk);
        rd_gnt = 1'b0;
        lst = (eb == rem);
        check(eof0 == (lst && m_buf == 0), "R7", "eof0 after grant", eof0, lst && m_buf == 0);
        check(eof1 == (lst && m_buf == 1), "R7", "eof1 after grant", eof1, lst && m_buf == 1);
        if (lst) begin
            m_buf = pingpong ? 1 - m_buf : 0;
            load_pass();
        end else begin
            w_ptr = w_ptr + 32'(eb * 4);
            first_of_pass = 0;
        end
        for (int k = 0; k < gap; k++) begin
            check(!rd_req, "R2", "no request while fifo_want low", rd_req, 0);
            @(negedge clk);
        end
        fifo_want = 1'b1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        m_start[0] = '0; m_ceil[0] = '0; m_start[1] = '0; m_ceil[1] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!rd_req, "R1", "rd_req in reset", rd_req, 0);
        check(!eof0 && !eof1, "R1", "eof in reset", eof0 | eof1, 0);
        rst_n = 1'b1;
        // directed config: region 0 = 10 words, region 1 = one word
        @(negedge clk);
        write_reg(0, 32'h0000_2000);
        write_reg(1, 32'h0000_2000 + 32'd39);
        write_reg(2, 32'h0000_8000);
        write_reg(3, 32'h0000_8000);
        for (int k = 0; k < 5; k++) begin
            check(!rd_req, "R1", "no request while run low", rd_req, 0);
            @(negedge clk);
        end
        run = 1'b1;
        m_buf = 0;
        load_pass();
        // two single-mode passes of region 0: bursts 4,4,2
        for (int i = 0; i < 6; i++) do_burst(0, i % 2, (i == 1) ? 3 : 0);
        // switch to ping-pong with fallback code while mid-pass
        do_burst(2, 0, 0);
        for (int i = 0; i < 12; i++) do_burst(0, 0, 0);
        // random phase
        for (int i = 0; i < 400 && !hung; i++)
            do_burst(1, int'($urandom % 3), ($urandom % 5 == 0) ? int'($urandom % 4) : 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule